// File: doc/BRIEF.md
# Warp Issue Scheduler

The scheduler sits between a per-warp operand scoreboard and the shared execution lanes of a multithreaded streaming core. It holds a table of resident warp slots (24 by default, enough for three resident thread groups of 256 threads split into 32-thread warps). Every cycle it picks at most one warp whose next instruction has its operands ready and names it on the issue outputs. All threads of that warp then execute the same instruction. Changing from one warp to another costs nothing, so a different warp may issue in every cycle.

Slots are filled through an allocate port, which also sets the slot's priority, and emptied through a retire port. The scoreboard raises a per-slot ready-set pulse when a warp's operands become available. Among the eligible warps, the one with the highest priority wins. Ties among equal priorities are resolved round-robin, starting from the slot just after the one that issued last. A warp that issues loses its ready bit until the scoreboard sets it again.

The issue outputs depend only on the registered slot table. A ready-set pulse presented in one cycle can therefore cause an issue in the next cycle at the earliest.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every slot is empty and not ready, issue_valid is low, and the round-robin pointer is at the last slot. The first tie search therefore starts at slot 0.
- R2: issue_valid is high only when some slot is both allocated and ready. issue_id then names such a slot, and its value is below NUM_WARPS.
- R3: The issued warp has the numerically highest priority among all eligible warps. Priority 3 is the most urgent and 0 the least.
- R4: Among eligible warps of equal top priority, the winner is the first one found when searching upward from the slot after the last issued warp, wrapping from NUM_WARPS-1 to 0.
- R5: The issued warp's ready bit is cleared at the issuing clock edge. A ready_set pulse for that same slot at that same edge is lost, so the warp cannot issue again until a later ready_set.
- R6: Whenever at least one warp is eligible, issue_valid is high in that cycle. There is no idle cycle between issues to different warps.
- R7: An allocate pulse with alloc_id below NUM_WARPS marks that slot occupied, stores alloc_prio, and clears its ready bit. An allocate to an occupied slot overwrites it.
- R8: A retire pulse with retire_id below NUM_WARPS empties that slot and clears its ready bit. It takes precedence over an allocate or a ready_set to the same slot in the same cycle.
- R9: A ready_set bit for an unoccupied slot has no effect. The slot stays not ready even after a later allocate.
- R10: Allocate and retire pulses whose id is NUM_WARPS or above change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate pulse |
| alloc_id | input | ID_W (5) | Slot to allocate |
| alloc_prio | input | PRIO_W (2) | Priority stored for the allocated warp |
| retire_valid | input | 1 | Retire pulse |
| retire_id | input | ID_W (5) | Slot to retire |
| ready_set | input | NUM_WARPS (24) | Per-slot operands-ready pulses from the scoreboard |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_id | output | ID_W (5) | Slot number of the issuing warp |

## Verification
A corrupted ready bit shows up within one cycle. Either a warp issues twice with no ready_set in between, or an eligible warp is never named. A wrong round-robin pointer shows on the very next tie as an out-of-order issue_id. The bench exposes this by sweeping all 24 equal-priority slots and expecting the ids 0 to 23 in strict order. A stale priority or a retire that was not applied surfaces at the first cycle where that slot competes. The bench's arithmetic model compares the expected winner against issue_id in every cycle of directed and pseudo-random traffic.

// File: rtl/wis_pkg.sv
package wis_pkg;

  localparam int DEF_NUM_WARPS = 24;
  localparam int DEF_PRIO_W    = 2;

  // Slot reached by stepping 'step' places forward from 'base' on a ring of n.
  function automatic int ring_step(int base, int step, int n);
    return (base + step) % n;
  endfunction

  // Slot-table update for one ready bit.
  // Precedence: retire/alloc clear > issue clear > scoreboard set.
  function automatic logic next_ready(logic cur, logic occupied, logic set_req,
                                      logic issued, logic wipe);
    logic r;
    r = cur;
    if (set_req && occupied) r = 1'b1;
    if (issued)              r = 1'b0;
    if (wipe)                r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/wis_slot_table.sv
module wis_slot_table #(
  parameter int NUM_WARPS = 24,
  parameter int PRIO_W    = 2,
  parameter int ID_W      = $clog2(NUM_WARPS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_valid,
  input  logic [ID_W-1:0]                  alloc_id,
  input  logic [PRIO_W-1:0]                alloc_prio,
  input  logic                             retire_valid,
  input  logic [ID_W-1:0]                  retire_id,
  input  logic [NUM_WARPS-1:0]             ready_set,
  input  logic                             issue_valid,
  input  logic [ID_W-1:0]                  issue_id,
  output logic [NUM_WARPS-1:0]             occupied_q,
  output logic [NUM_WARPS-1:0]             ready_q,
  output logic [NUM_WARPS-1:0][PRIO_W-1:0] prio_q
);
  import wis_pkg::*;

  for (genvar s = 0; s < NUM_WARPS; s++) begin : g_slot
    logic hit_ret, hit_alloc, hit_issue;

    assign hit_ret   = retire_valid && (retire_id == ID_W'(s));
    assign hit_alloc = alloc_valid  && (alloc_id  == ID_W'(s));
    assign hit_issue = issue_valid  && (issue_id  == ID_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occupied_q[s] <= 1'b0;
        ready_q[s]    <= 1'b0;
        prio_q[s]     <= '0;
      end else begin
        if (hit_ret)        occupied_q[s] <= 1'b0;
        else if (hit_alloc) occupied_q[s] <= 1'b1;
        if (hit_alloc && !hit_ret) prio_q[s] <= alloc_prio;
        ready_q[s] <= next_ready(ready_q[s], occupied_q[s], ready_set[s],
                                 hit_issue, hit_ret || hit_alloc);
      end
    end
  end

endmodule

// File: rtl/wis_prio_max.sv
module wis_prio_max #(
  parameter int NUM_WARPS = 24,
  parameter int PRIO_W    = 2
) (
  input  logic [NUM_WARPS-1:0]             elig,
  input  logic [NUM_WARPS-1:0][PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0]                best_prio,
  output logic [NUM_WARPS-1:0]             top_cand
);
  always_comb begin
    best_prio = '0;
    for (int s = 0; s < NUM_WARPS; s++) begin
      if (elig[s] && (prio[s] > best_prio)) best_prio = prio[s];
    end
  end

  for (genvar s = 0; s < NUM_WARPS; s++) begin : g_cand
    assign top_cand[s] = elig[s] && (prio[s] == best_prio);
  end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int NUM_WARPS = 24,
  parameter int ID_W      = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] cand,
  input  logic [ID_W-1:0]      last_id,
  output logic                 found,
  output logic [ID_W-1:0]      pick_id
);
  import wis_pkg::*;

  // Walk from farthest to nearest, so the nearest candidate after last_id wins.
  always_comb begin
    found   = 1'b0;
    pick_id = '0;
    for (int k = NUM_WARPS; k >= 1; k--) begin
      int idx;
      idx = ring_step(int'(last_id), k, NUM_WARPS);
      if (cand[idx]) begin
        found   = 1'b1;
        pick_id = ID_W'(idx);
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = wis_pkg::DEF_NUM_WARPS,
  parameter int PRIO_W    = wis_pkg::DEF_PRIO_W,
  parameter int ID_W      = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [ID_W-1:0]      alloc_id,
  input  logic [PRIO_W-1:0]    alloc_prio,
  input  logic                 retire_valid,
  input  logic [ID_W-1:0]      retire_id,
  input  logic [NUM_WARPS-1:0] ready_set,
  output logic                 issue_valid,
  output logic [ID_W-1:0]      issue_id
);
  localparam logic [ID_W-1:0] LAST_SLOT = ID_W'(NUM_WARPS - 1);

  // Named internal events, also observed by the bound checker.
  logic [NUM_WARPS-1:0]             occupied_vec;
  logic [NUM_WARPS-1:0]             ready_vec;
  logic [NUM_WARPS-1:0][PRIO_W-1:0] prio_vec;
  logic [NUM_WARPS-1:0]             elig_vec;
  logic [NUM_WARPS-1:0]             top_vec;
  logic [PRIO_W-1:0]                best_prio;
  logic [ID_W-1:0]                  last_q;
  logic                             pick_found;
  logic [ID_W-1:0]                  pick_id;

  wis_slot_table #(.NUM_WARPS(NUM_WARPS), .PRIO_W(PRIO_W), .ID_W(ID_W)) table_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_id     (alloc_id),
    .alloc_prio   (alloc_prio),
    .retire_valid (retire_valid),
    .retire_id    (retire_id),
    .ready_set    (ready_set),
    .issue_valid  (issue_valid),
    .issue_id     (issue_id),
    .occupied_q   (occupied_vec),
    .ready_q      (ready_vec),
    .prio_q       (prio_vec)
  );

  assign elig_vec = occupied_vec & ready_vec;

  wis_prio_max #(.NUM_WARPS(NUM_WARPS), .PRIO_W(PRIO_W)) prio_i (
    .elig      (elig_vec),
    .prio      (prio_vec),
    .best_prio (best_prio),
    .top_cand  (top_vec)
  );

  wis_rr_pick #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) rr_i (
    .cand    (top_vec),
    .last_id (last_q),
    .found   (pick_found),
    .pick_id (pick_id)
  );

  assign issue_valid = pick_found;
  assign issue_id    = pick_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_q <= LAST_SLOT;
    else if (issue_valid) last_q <= issue_id;
  end

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 24,
  parameter int PRIO_W    = 2,
  parameter int ID_W      = $clog2(NUM_WARPS)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             retire_valid,
  input logic [ID_W-1:0]                  retire_id,
  input logic                             issue_valid,
  input logic [ID_W-1:0]                  issue_id,
  input logic [NUM_WARPS-1:0]             occupied_vec,
  input logic [NUM_WARPS-1:0]             ready_vec,
  input logic [NUM_WARPS-1:0][PRIO_W-1:0] prio_vec
);
  logic outranked;
  logic issued_elig;
  logic any_elig;

  always_comb begin
    outranked   = 1'b0;
    issued_elig = 1'b0;
    any_elig    = 1'b0;
    for (int s = 0; s < NUM_WARPS; s++) begin
      if (occupied_vec[s] && ready_vec[s]) begin
        any_elig = 1'b1;
        if (int'(issue_id) < NUM_WARPS && prio_vec[s] > prio_vec[issue_id]) outranked = 1'b1;
        if (ID_W'(s) == issue_id) issued_elig = 1'b1;
      end
    end
  end

  AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> issued_elig); // R2

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (int'(issue_id) < NUM_WARPS)); // R2

  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !outranked); // R3

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !ready_vec[$past(issue_id)]); // R5

  AST_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |-> issue_valid); // R6

  AST_RETIRE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && int'(retire_id) < NUM_WARPS) |=>
      !occupied_vec[$past(retire_id)] && !ready_vec[$past(retire_id)]); // R8

endmodule

bind warp_issue_sched wis_checker #(
  .NUM_WARPS(NUM_WARPS), .PRIO_W(PRIO_W), .ID_W(ID_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_valid (retire_valid),
  .retire_id    (retire_id),
  .issue_valid  (issue_valid),
  .issue_id     (issue_id),
  .occupied_vec (occupied_vec),
  .ready_vec    (ready_vec),
  .prio_vec     (prio_vec)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 24;
  localparam int PW = 2;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [IW-1:0] alloc_id = '0;
  logic [PW-1:0] alloc_prio = '0;
  logic          retire_valid = 1'b0;
  logic [IW-1:0] retire_id = '0;
  logic [NW-1:0] ready_set = '0;
  logic          issue_valid;
  logic [IW-1:0] issue_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .PRIO_W(PW), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_id(alloc_id), .alloc_prio(alloc_prio),
    .retire_valid(retire_valid), .retire_id(retire_id), .ready_set(ready_set),
    .issue_valid(issue_valid), .issue_id(issue_id)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model
  bit m_occ [NW];
  bit m_rdy [NW];
  int m_pri [NW];
  int m_last = NW - 1;
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  // Winner key: priority dominates, then closeness after the last issuer.
  function automatic int expect_pick();
    int best_key = -1;
    int best_id = -1;
    for (int i = 0; i < NW; i++) begin
      if (m_occ[i] && m_rdy[i]) begin
        int key;
        key = m_pri[i] * NW + (NW - 1 - ((i - m_last - 1 + NW) % NW));
        if (key > best_key) begin
          best_key = key;
          best_id = i;
        end
      end
    end
    return best_id;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp_v, string what);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  // One cycle: drive inputs, check outputs against model, advance model and clock.
  task automatic step(string req, bit av, int aid, int ap, bit rv, int rid, logic [NW-1:0] sv);
    int e;
    alloc_valid = av; alloc_id = IW'(aid); alloc_prio = PW'(ap);
    retire_valid = rv; retire_id = IW'(rid); ready_set = sv;
    e = expect_pick();
    check(req, 32'(issue_valid), 32'(e >= 0), "issue_valid");
    if (e >= 0) check(req, 32'(issue_id), 32'(e), "issue_id");
    for (int i = 0; i < NW; i++) begin
      bit wipe;
      wipe = (rv && rid == i) || (av && aid == i);
      if (sv[i] && m_occ[i]) m_rdy[i] = 1;
      if (e == i) m_rdy[i] = 0;
      if (wipe) m_rdy[i] = 0;
      if (av && aid == i && !(rv && rid == i)) begin
        m_occ[i] = 1; m_pri[i] = ap;
      end
      if (rv && rid == i) m_occ[i] = 0;
    end
    if (e >= 0) m_last = e;
    @(posedge clk); #1;
  endtask

  task automatic idle(string req, int n);
    for (int k = 0; k < n; k++) step(req, 0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin m_occ[i] = 0; m_rdy[i] = 0; m_pri[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    check("R1", 32'(issue_valid), 0, "issue_valid after reset");
    // R9: ready_set on empty slots is ignored, even after later allocate
    step("R9", 0, 0, 0, 0, 0, {NW{1'b1}});
    check("R9", 32'(issue_valid), 0, "issue_valid after set on empty slots");
    // R7: allocate clears ready
    for (int i = 0; i < NW; i++) step("R7", 1, i, 1, 0, 0, '0);
    idle("R9", 2);
    check("R9", 32'(issue_valid), 0, "no issue after alloc of pre-set slots");
    // R4/R6: equal priority, all ready -> 0..23 consecutively
    step("R4", 0, 0, 0, 0, 0, {NW{1'b1}});
    for (int k = 0; k < NW; k++) begin
      check("R6", 32'(issue_valid), 1, "issue every cycle");
      check("R4", 32'(issue_id), 32'(k), "round-robin order");
      step("R4", 0, 0, 0, 0, 0, '0);
    end
    // R5: nothing re-issues without a new set
    check("R5", 32'(issue_valid), 0, "ready cleared after issue");
    idle("R5", 2);
    // R3: priority dominance
    step("R7", 1, 10, 3, 0, 0, '0);
    step("R3", 0, 0, 0, 0, 0, (NW'(1) << 3) | (NW'(1) << 10) | (NW'(1) << 20));
    check("R3", 32'(issue_id), 10, "high priority first");
    idle("R3", 3);
    // R5: set held while issuing -> lost, warp 5 issues every other cycle
    for (int k = 0; k < 8; k++) step("R5", 0, 0, 0, 0, 0, NW'(1) << 5);
    idle("R5", 2);
    // R8: retire beats set and alloc
    step("R8", 0, 0, 0, 1, 7, NW'(1) << 7);
    step("R8", 1, 8, 2, 1, 8, '0);
    step("R8", 0, 0, 0, 0, 0, (NW'(1) << 7) | (NW'(1) << 8));
    check("R8", 32'(issue_valid), 0, "retired slots never issue");
    idle("R8", 1);
    // R10: out-of-range ids do nothing; retire 30 must not alias slot 6
    step("R10", 1, 28, 3, 1, 30, '0);
    step("R10", 0, 0, 0, 0, 0, NW'(1) << 6);
    check("R10", 32'(issue_id), 6, "slot 6 survives out-of-range retire");
    idle("R10", 2);
    // R7: reallocation of an occupied slot overwrites priority
    step("R7", 1, 4, 0, 0, 0, '0);
    step("R7", 0, 0, 0, 0, 0, (NW'(1) << 4) | (NW'(1) << 9));
    check("R7", 32'(issue_id), 9, "overwritten priority used");
    idle("R7", 3);
    // R2/R3/R4: pseudo-random traffic
    for (int i = 0; i < NW; i++) step("R7", 1, i, int'(rnd() % 4), 0, 0, '0);
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = rnd();
      step("R2", (r[1:0] == 0), int'((r >> 2) % 27), int'(r[9:8]),
           (r[14:12] == 0), int'((r >> 16) % 26), NW'(rnd() & rnd()));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule